// File: doc/BRIEF.md
# Configuration Address/Data Window Bridge

This block gives a host an indirect path into the configuration space of a set of devices. Software first writes a 32-bit target word into an address register, then reads or writes a data window. Each data-window access is turned into a single configuration transaction toward a device array. When the access cannot be carried out, reads come back as all-ones and writes are dropped without any side effect.

The host side uses a valid/ready handshake. `host_sel` picks the address register (0) or the data window (1). `host_offs` is the byte offset within the selected register. `host_size` encodes the length: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Every read produces exactly one `rsp_valid` pulse; writes produce none.

The device side has four inputs: presence, power, hot-added and function-0-present flags. They describe the function addressed by `dev_req_bus`/`dev_req_devfn`. The block samples them one cycle after it accepts a data-window access. It then issues a one-cycle request, and for reads it waits for a one-cycle `dev_rsp_valid`. The parameter `CFG_LIMIT` (1 to 256) sets the end of the reachable configuration space.

Top module: `cfg_window_bridge`

## Requirements
- R1: The address register is loaded only by a write with `host_offs`=0 and a 4-byte size code (2 or 3). A write with any other offset or size leaves it unchanged.
- R2: A read of the address register returns the full 32-bit latched value, whatever `host_offs` and `host_size` are. The response arrives one cycle after acceptance.
- R3: After reset the address register reads as zero, so a data-window read returns 0xFFFFFFFF.
- R4: While bit 31 of the address register is 0, a data-window read returns 0xFFFFFFFF and a data-window write issues no device request.
- R5: The effective address is the latched value ORed with `host_offs`. Bits 23:16 go out as the bus number, bits 15:8 as device/function, and bits 7:0 as the byte offset.
- R6: If `dev_present` is low for the addressed function, a read returns 0xFFFFFFFF and a write issues no request.
- R7: An access is rejected in the same way if `dev_powered` is low. It is also rejected if `dev_hotadd` is high, the function number (devfn bits 2:0) is non-zero, and `dev_fn0_present` is low.
- R8: An effective offset at or above `CFG_LIMIT` is rejected: reads return all-ones and writes issue no request.
- R9: The transfer length is the smaller of the requested length and `CFG_LIMIT` minus the offset. `dev_req_be` carries that length as a mask of consecutive low bits: 0001, 0011, 0111 or 1111.
- R10: Each accepted read gives exactly one `rsp_valid` pulse; a write gives none. Read data bytes outside `dev_req_be` are returned as zero.
- R11: A data-window write that passes every check issues one request with `dev_req_write`=1. The request carries the host write data unchanged, with byte 0 as the first addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access offered |
| host_ready | output | 1 | Bridge idle and able to accept |
| host_write | input | 1 | 1 write, 0 read |
| host_sel | input | 1 | 0 address register, 1 data window |
| host_offs | input | 2 | Byte offset inside the register |
| host_size | input | 2 | Size code: 0=1, 1=2, 2/3=4 bytes |
| host_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read data valid, one pulse per read |
| rsp_rdata | output | 32 | Read data |
| dev_req_valid | output | 1 | Device request pulse |
| dev_req_write | output | 1 | Request is a write |
| dev_req_bus | output | 8 | Target bus number |
| dev_req_devfn | output | 8 | Target device/function |
| dev_req_offs | output | 8 | Byte offset in configuration space |
| dev_req_be | output | 4 | Length mask after clamping |
| dev_req_wdata | output | 32 | Write data |
| dev_present | input | 1 | Addressed function exists |
| dev_powered | input | 1 | Addressed function is powered |
| dev_hotadd | input | 1 | Addressed function was hot-added |
| dev_fn0_present | input | 1 | Function 0 of the same slot exists |
| dev_rsp_valid | input | 1 | Device read data valid |
| dev_rsp_rdata | input | 32 | Device read data |

## Verification
Delivering a read response and accepting the next host access can happen in the same cycle. The response pulse and the return of `host_ready` fall on the same edge. The bench provokes this by holding an address-register write valid while a data-window read is still in flight. The read data must reflect the old target, and the new value must then read back from the address register. Near the limit, the clamp and the reject decision meet in one comparison; the sweep crosses that boundary with every offset and size.

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge #(
  parameter int CFG_LIMIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        host_write,
  input  logic        host_sel,
  input  logic [1:0]  host_offs,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        dev_req_valid,
  output logic        dev_req_write,
  output logic [7:0]  dev_req_bus,
  output logic [7:0]  dev_req_devfn,
  output logic [7:0]  dev_req_offs,
  output logic [3:0]  dev_req_be,
  output logic [31:0] dev_req_wdata,
  input  logic        dev_present,
  input  logic        dev_powered,
  input  logic        dev_hotadd,
  input  logic        dev_fn0_present,
  input  logic        dev_rsp_valid,
  input  logic [31:0] dev_rsp_rdata
);

  localparam logic [9:0] LIMIT_V = 10'(CFG_LIMIT);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ISSUE, S_WAIT} st_t;

  st_t         st_q;
  logic [31:0] latch_q, wdata_q, rsp_q;
  logic [23:0] eff_q;
  logic        wr_q, rsp_v_q;
  logic [2:0]  len_q, req_len, eff_len;
  logic [3:0]  be_q, be_n;
  logic [9:0]  rem;
  logic        acc, in_range, fn_gone, tgt_ok;
  logic [31:0] lane_mask;

  assign host_ready = (st_q == S_IDLE);
  assign acc        = host_valid && host_ready;

  always_comb begin
    case (host_size)
      2'd0:    req_len = 3'd1;
      2'd1:    req_len = 3'd2;
      default: req_len = 3'd4;
    endcase
  end

  assign rem      = LIMIT_V - {2'b00, eff_q[7:0]};
  assign in_range = {2'b00, eff_q[7:0]} < LIMIT_V;
  assign fn_gone  = dev_hotadd && (eff_q[10:8] != 3'd0) && !dev_fn0_present;
  assign tgt_ok   = dev_present && dev_powered && !fn_gone && in_range;
  assign eff_len  = (rem < {7'd0, len_q}) ? rem[2:0] : len_q;

  always_comb begin
    case (eff_len)
      3'd1:    be_n = 4'b0001;
      3'd2:    be_n = 4'b0011;
      3'd3:    be_n = 4'b0111;
      default: be_n = 4'b1111;
    endcase
  end

  assign lane_mask = {{8{be_q[3]}}, {8{be_q[2]}}, {8{be_q[1]}}, {8{be_q[0]}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      latch_q <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
      eff_q   <= '0;
      wr_q    <= 1'b0;
      rsp_v_q <= 1'b0;
      len_q   <= '0;
      be_q    <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (acc) begin
            if (!host_sel) begin
              if (host_write) begin
                if (host_offs == 2'd0 && host_size[1]) latch_q <= host_wdata;
              end else begin
                rsp_v_q <= 1'b1;
                rsp_q   <= latch_q;
              end
            end else if (!latch_q[31]) begin
              if (!host_write) begin
                rsp_v_q <= 1'b1;
                rsp_q   <= '1;
              end
            end else begin
              eff_q   <= latch_q[23:0] | {22'd0, host_offs};
              wr_q    <= host_write;
              wdata_q <= host_wdata;
              len_q   <= req_len;
              st_q    <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (tgt_ok) begin
            be_q <= be_n;
            st_q <= S_ISSUE;
          end else begin
            if (!wr_q) begin
              rsp_v_q <= 1'b1;
              rsp_q   <= '1;
            end
            st_q <= S_IDLE;
          end
        end
        S_ISSUE: st_q <= wr_q ? S_IDLE : S_WAIT;
        S_WAIT: begin
          if (dev_rsp_valid) begin
            rsp_v_q <= 1'b1;
            rsp_q   <= dev_rsp_rdata & lane_mask;
            st_q    <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid     = rsp_v_q;
  assign rsp_rdata     = rsp_q;
  assign dev_req_valid = (st_q == S_ISSUE);
  assign dev_req_write = wr_q;
  assign dev_req_bus   = eff_q[23:16];
  assign dev_req_devfn = eff_q[15:8];
  assign dev_req_offs  = eff_q[7:0];
  assign dev_req_be    = be_q;
  assign dev_req_wdata = wdata_q;

endmodule

// File: rtl/cfg_window_bridge_chk.sv
module cfg_window_bridge_chk #(
  parameter int CFG_LIMIT = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_valid,
  input logic        host_ready,
  input logic        host_write,
  input logic        host_sel,
  input logic [1:0]  host_offs,
  input logic [1:0]  host_size,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        dev_req_valid,
  input logic [7:0]  dev_req_offs,
  input logic [3:0]  dev_req_be,
  input logic [31:0] latch_q
);

  p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_sel && host_write &&
     (host_offs != 2'd0 || !host_size[1])) |=> $stable(latch_q));

  p_addr_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_sel && !host_write) |=>
      (rsp_valid && rsp_rdata == $past(latch_q)));

  p_disabled_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && host_sel && !host_write && !latch_q[31]) |=>
      (rsp_valid && rsp_rdata == 32'hFFFF_FFFF));

  p_disabled_noreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && host_sel && !latch_q[31]) |=> !dev_req_valid);

  p_offs_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_valid |-> ({2'b00, dev_req_offs} < 10'(CFG_LIMIT)));

  p_be_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_valid |-> (dev_req_be == 4'b0001 || dev_req_be == 4'b0011 ||
                       dev_req_be == 4'b0111 || dev_req_be == 4'b1111));

  p_rsp_at_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> host_ready);

  p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_valid |-> (!host_ready && !rsp_valid));

endmodule

bind cfg_window_bridge cfg_window_bridge_chk #(.CFG_LIMIT(CFG_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
  .host_write(host_write), .host_sel(host_sel), .host_offs(host_offs),
  .host_size(host_size), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .dev_req_valid(dev_req_valid), .dev_req_offs(dev_req_offs),
  .dev_req_be(dev_req_be), .latch_q(latch_q)
);

// File: tb/cfg_window_bridge_tb_top.sv
module cfg_window_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        host_valid = 1'b0, host_write = 1'b0, host_sel = 1'b0;
  logic [1:0]  host_offs = '0, host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        dev_req_valid, dev_req_write;
  logic [7:0]  dev_req_bus, dev_req_devfn, dev_req_offs;
  logic [3:0]  dev_req_be;
  logic [31:0] dev_req_wdata;
  logic        dev_present, dev_powered, dev_hotadd, dev_fn0_present;
  logic        dev_rsp_valid = 1'b0;
  logic [31:0] dev_rsp_rdata = '0;

  cfg_window_bridge #(.CFG_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_sel(host_sel), .host_offs(host_offs), .host_size(host_size),
    .host_wdata(host_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dev_req_valid(dev_req_valid), .dev_req_write(dev_req_write),
    .dev_req_bus(dev_req_bus), .dev_req_devfn(dev_req_devfn),
    .dev_req_offs(dev_req_offs), .dev_req_be(dev_req_be),
    .dev_req_wdata(dev_req_wdata), .dev_present(dev_present),
    .dev_powered(dev_powered), .dev_hotadd(dev_hotadd),
    .dev_fn0_present(dev_fn0_present), .dev_rsp_valid(dev_rsp_valid),
    .dev_rsp_rdata(dev_rsp_rdata)
  );

  function automatic bit f_pres(input logic [7:0] b, input logic [7:0] df);
    return (b == 8'd1) || (df[3] == 1'b0) || (df[2:0] == 3'd6);
  endfunction
  function automatic bit f_pow(input logic [7:0] df);
    return df[2:0] != 3'd3;
  endfunction
  function automatic bit f_hot(input logic [7:0] df);
    return (df[2:0] == 3'd6) || (df[2:0] == 3'd2);
  endfunction
  function automatic logic [31:0] f_stub(input logic [7:0] b, input logic [7:0] df, input logic [7:0] off);
    return {off, df, b, 8'h5A};
  endfunction
  function automatic bit f_ok(input logic [7:0] b, input logic [7:0] df, input int off);
    bit gone;
    gone = f_hot(df) && (df[2:0] != 3'd0) && !f_pres(b, {df[7:3], 3'b000});
    return f_pres(b, df) && f_pow(df) && !gone && (off < LIMIT);
  endfunction
  function automatic int f_len(input int off, input int sz);
    int req;
    req = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    return (LIMIT - off < req) ? LIMIT - off : req;
  endfunction
  function automatic logic [31:0] f_exp_rd(input logic [7:0] b, input logic [7:0] df, input int off, input int sz);
    logic [31:0] m;
    if (!f_ok(b, df, off)) return 32'hFFFF_FFFF;
    m = '0;
    for (int i = 0; i < f_len(off, sz); i++) m[i*8 +: 8] = 8'hFF;
    return f_stub(b, df, 8'(off)) & m;
  endfunction

  assign dev_present     = f_pres(dev_req_bus, dev_req_devfn);
  assign dev_powered     = f_pow(dev_req_devfn);
  assign dev_hotadd      = f_hot(dev_req_devfn);
  assign dev_fn0_present = f_pres(dev_req_bus, {dev_req_devfn[7:3], 3'b000});

  int rsp_cnt = 0, req_cnt = 0;
  logic [31:0] last_fields = '0, last_wdata = '0;
  always @(posedge clk) begin
    dev_rsp_valid <= dev_req_valid && !dev_req_write;
    dev_rsp_rdata <= f_stub(dev_req_bus, dev_req_devfn, dev_req_offs);
    if (rsp_valid) rsp_cnt <= rsp_cnt + 1;
    if (dev_req_valid) begin
      req_cnt <= req_cnt + 1;
      last_fields <= {dev_req_bus, dev_req_devfn, dev_req_offs, 3'b000, dev_req_write, dev_req_be};
      last_wdata <= dev_req_wdata;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_op(input bit sel, input bit wr, input logic [1:0] offs,
                         input logic [1:0] size, input logic [31:0] wd,
                         output logic [31:0] rd);
    @(negedge clk);
    host_valid = 1'b1; host_sel = sel; host_write = wr;
    host_offs = offs; host_size = size; host_wdata = wd;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    rd = 32'hDEAD_BEEF;
    if (!wr) begin
      for (int k = 0; k < 30; k++) begin
        if (rsp_valid) begin rd = rsp_rdata; break; end
        @(negedge clk);
      end
      repeat (3) @(negedge clk);
    end else begin
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic set_latch(input logic [31:0] v);
    logic [31:0] d;
    host_op(1'b0, 1'b1, 2'd0, 2'd2, v, d);
  endtask

  task automatic rd_chk(input string req, input bit sel, input logic [1:0] offs,
                        input logic [1:0] size, input logic [31:0] exp);
    logic [31:0] d;
    int c0;
    c0 = rsp_cnt;
    host_op(sel, 1'b0, offs, size, 32'h0, d);
    chk(req, d, exp);
    chk("R10 one response per read", 32'(rsp_cnt - c0), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c0, r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd_chk("R3 latch zero after reset", 1'b0, 2'd0, 2'd2, 32'h0);
    rd_chk("R3 data read disabled after reset", 1'b1, 2'd0, 2'd2, 32'hFFFF_FFFF);

    set_latch(32'h1234_5678);
    host_op(1'b0, 1'b1, 2'd1, 2'd2, 32'hAAAA_AAAA, d);
    rd_chk("R1 offset 1 write ignored", 1'b0, 2'd0, 2'd2, 32'h1234_5678);
    host_op(1'b0, 1'b1, 2'd0, 2'd1, 32'hBBBB_BBBB, d);
    rd_chk("R1 2-byte write ignored", 1'b0, 2'd0, 2'd2, 32'h1234_5678);
    host_op(1'b0, 1'b1, 2'd0, 2'd3, 32'h0C0C_0C0C, d);
    rd_chk("R1 size code 3 write loads", 1'b0, 2'd0, 2'd2, 32'h0C0C_0C0C);
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 3; s++)
        rd_chk("R2 readback any offset/size", 1'b0, 2'(o), 2'(s), 32'h0C0C_0C0C);

    set_latch(32'h0001_0010);
    rd_chk("R4 read with enable clear", 1'b1, 2'd0, 2'd2, 32'hFFFF_FFFF);
    r0 = req_cnt;
    host_op(1'b1, 1'b1, 2'd0, 2'd2, 32'h1111_2222, d);
    chk("R4 write with enable clear issues nothing", 32'(req_cnt - r0), 32'd0);

    set_latch(32'h8001_0011);
    rd_chk("R5 offset OR merge", 1'b1, 2'd2, 2'd2, f_stub(8'd1, 8'd0, 8'h13));

    for (int b = 0; b < 2; b++)
      for (int df = 0; df < 16; df++)
        for (int ri = 0; ri < 3; ri++) begin
          int rg;
          rg = (ri == 0) ? 'h10 : (ri == 1) ? 'hEC : 'hF0;
          set_latch({1'b1, 7'd0, 8'(b), 8'(df), 8'(rg)});
          for (int o = 0; o < 4; o++)
            for (int s = 0; s < 3; s++)
              rd_chk("R5 R6 R7 R8 R9 R10 read sweep", 1'b1, 2'(o), 2'(s),
                     f_exp_rd(8'(b), 8'(df), rg + o, s));
        end

    for (int b = 0; b < 2; b++)
      for (int df = 0; df < 16; df++) begin
        logic [31:0] wd;
        wd = {8'(b), 8'(df), 8'h77, 8'h11};
        set_latch({1'b1, 7'd0, 8'(b), 8'(df), 8'hEC});
        r0 = req_cnt; c0 = rsp_cnt;
        host_op(1'b1, 1'b1, 2'd2, 2'd2, wd, d);
        chk("R10 no response for write", 32'(rsp_cnt - c0), 32'd0);
        if (f_ok(8'(b), 8'(df), 'hEE)) begin
          chk("R11 one write request", 32'(req_cnt - r0), 32'd1);
          chk("R9 R11 write fields", last_fields,
              {8'(b), 8'(df), 8'hEE, 3'b000, 1'b1, 4'b0011});
          chk("R11 write data", last_wdata, wd);
        end else begin
          chk("R6 R7 rejected write issues nothing", 32'(req_cnt - r0), 32'd0);
        end
      end

    set_latch(32'h8000_00F0);
    r0 = req_cnt;
    host_op(1'b1, 1'b1, 2'd0, 2'd0, 32'h5, d);
    chk("R8 write at limit issues nothing", 32'(req_cnt - r0), 32'd0);

    set_latch(32'h8001_0520);
    c0 = rsp_cnt;
    @(negedge clk);
    host_valid = 1'b1; host_sel = 1'b1; host_write = 1'b0;
    host_offs = 2'd0; host_size = 2'd2;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_sel = 1'b0; host_write = 1'b1; host_wdata = 32'h8001_0630;
    while (!host_ready) @(negedge clk);
    chk("R10 response with next accept", {31'd0, rsp_valid}, 32'd1);
    chk("R10 in-flight read uses old target", rsp_rdata, f_stub(8'd1, 8'd5, 8'h20));
    @(negedge clk);
    host_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 single response in overlap", 32'(rsp_cnt - c0), 32'd1);
    rd_chk("R1 overlapped latch write took effect", 1'b0, 2'd0, 2'd2, 32'h8001_0630);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule